// File: doc/BRIEF.md
# PC System Timer Subsystem

This block is the interval-timer corner of a PC-compatible south bridge. It holds three 16-bit down-counters. They share one counting rate: a single-clock prescaler emits an enable pulse once every twelve cycles of the 14.31818 MHz oscillator, which gives about 1.193 MHz. No derived clock is generated.

Software programs each counter with a control byte and then writes the count through an 8-bit register port. Three counting behaviours are offered:

- a terminal-count mode that raises its output once and holds it there;
- a rate generator that drops its output for one count period per cycle;
- a square-wave generator.

All counting is binary.

The connections around the counters are fixed. Counters 0 and 1 always count. Counter 0 drives the periodic interrupt request and counter 1 drives the memory-refresh request. Counter 2 is gated by one bit of a system control port, and its output reaches the speaker pin only while a second control-port bit is set.

Top module: `pc_timer_subsys`

## Requirements
- R1: In reset, and afterwards until a channel has accepted a control byte, that channel's output is low. Count bytes written to a channel before its control byte are ignored.
- R2: Every counter decrements once per twelve oscillator cycles. A rate-generator channel loaded with N therefore repeats every 12·N oscillator cycles.
- R3: In rate-generator mode the output is low for exactly one count period (12 oscillator cycles) per cycle and high for the remaining N−1 periods.
- R4: In square-wave mode with an even count N, the output is high for N/2 count periods and low for N/2 count periods.
- R5: In square-wave mode with an odd count N, the output is high for (N+1)/2 count periods and low for (N−1)/2 count periods.
- R6: In terminal-count mode, completing a count write drives the output low at once. The output rises N count periods after the first prescaler pulse that follows the write, and it then stays high until the next write.
- R7: Three byte orders are supported, set by control bits [5:4]:
  - 01 loads the low byte and clears the high byte;
  - 10 loads the high byte and clears the low byte;
  - 11 takes the low byte and then the high byte, and the count is not used until the second byte arrives.
- R8: The pin routing is fixed:
  - `irq0` carries channel 0;
  - `refresh_req` carries channel 1;
  - `speaker` is channel 2 ANDed with `port_spk_en`, so it is low whenever `port_spk_en` is low.
- R9: Channels 0 and 1 are always enabled. Channel 2 is gated by `port_gate2`. In rate-generator and square-wave modes, a low gate stops counting and forces the output high on the next cycle. When the gate returns high, the counter reloads and resumes.
- R10: In rate-generator and square-wave modes, a new count written while the channel is running leaves the current cycle untouched. The new count takes effect at the next reload.
- R11: A control byte is written at address 3 and has this layout:
  - channel select in bits [7:6];
  - byte order in bits [5:4];
  - mode in bits [3:1], where 000 is terminal count, x10 is rate generator and x11 is square wave;
  - a binary/decimal flag in bit 0.

  A control byte is ignored if it selects channel 3, has byte order 00, names any other mode, or sets bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | 14.31818 MHz oscillator clock, the only clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle per byte |
| bus_addr | input | 2 | 0–2 select a channel's count register, 3 the control register |
| bus_wdata | input | 8 | Write data byte |
| port_gate2 | input | 1 | System control port bit 0: gate of channel 2 |
| port_spk_en | input | 1 | System control port bit 1: speaker enable |
| irq0 | output | 1 | Periodic interrupt request (channel 0) |
| refresh_req | output | 1 | Memory-refresh request (channel 1) |
| speaker | output | 1 | Speaker drive (channel 2 AND speaker enable) |

## Verification
Outputs change only on the oscillator edge that carries a prescaler pulse. The first pulse after a count write lands 1 to 12 cycles after that write, so the first edge of every new waveform is waited out rather than timed. The scoreboard then checks each later high or low phase as an exact edge-to-edge length in oscillator cycles, sampled on the falling clock, and that length must equal twelve times the expected number of count periods. The one exception is the terminal-count rise: its latency from the write depends on the prescaler phase, so it is checked against the window of 49 to 60 cycles. Level checks on the speaker pin and on held outputs start two cycles after the control input changes and then sample every cycle for the whole window.

// File: rtl/pst_pkg.sv
`timescale 1ns/1ps
package pst_pkg;
   localparam int BYTE_W  = 8;
   localparam int COUNT_W = 2 * BYTE_W;
   localparam int NUM_CH  = 3;
   localparam logic [1:0] CTRL_ADDR = 2'd3;

   typedef enum logic [1:0] {
      MD_ONESHOT = 2'd0,
      MD_RATE    = 2'd2,
      MD_SQUARE  = 2'd3
   } cnt_mode_e;

   typedef enum logic [1:0] {
      AC_NONE = 2'd0,
      AC_LO   = 2'd1,
      AC_HI   = 2'd2,
      AC_LOHI = 2'd3
   } acc_e;

   typedef struct packed {
      logic [1:0] sel;
      acc_e       acc;
      logic [2:0] mode;
      logic       bcd;
   } ctrl_word_t;

   function automatic logic mode_ok(input logic [2:0] m);
      return (m == 3'b000) || m[1];
   endfunction

   function automatic cnt_mode_e mode_map(input logic [2:0] m);
      if (!m[1]) return MD_ONESHOT;
      return m[0] ? MD_SQUARE : MD_RATE;
   endfunction
endpackage

// File: rtl/pst_prescale.sv
`timescale 1ns/1ps
module pst_prescale #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("pst_prescale: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick = 1'b1;
   end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      localparam logic [PW-1:0] STEP = PW'(1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk) begin
         if (!rst_n) phase <= '0;
         else        phase <= (phase == LAST) ? '0 : phase + STEP;
      end

      assign tick = (phase == LAST);

      // R2: enable pulses are isolated single cycles
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/pst_channel.sv
`timescale 1ns/1ps
module pst_channel
   import pst_pkg::*;
#(
   parameter int COUNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 gate,
   input  logic                 cfg_we,
   input  cnt_mode_e            cfg_mode,
   input  acc_e                 cfg_acc,
   input  logic                 load_we,
   input  logic [COUNT_W/2-1:0] load_byte,
   output logic                 out_o
);
   localparam int HALF  = COUNT_W / 2;
   localparam int CNT_W = COUNT_W + 1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

   if (COUNT_W < 4 || (COUNT_W % 2) != 0) begin : g_bad_width
      $error("pst_channel: COUNT_W must be even and at least 4");
   end

   cnt_mode_e           mode_q;
   acc_e                acc_q;
   logic [CNT_W-1:0]    cnt;
   logic [COUNT_W-1:0]  reload;
   logic [HALF-1:0]     lo_hold;
   logic                hi_next, cfg_seen, running, pending, gate_q, out_q;

   logic [COUNT_W-1:0]  new_val;
   logic [CNT_W-1:0]    reload_ext, sq_high_val, sq_low_val;
   logic                first_half, load_done;

   // zero stands for the full range
   function automatic logic [CNT_W-1:0] ext(input logic [COUNT_W-1:0] v);
      return (v == '0) ? {1'b1, {COUNT_W{1'b0}}} : {1'b0, v};
   endfunction

   always_comb begin
      case (acc_q)
         AC_LO:   new_val = {{HALF{1'b0}}, load_byte};
         AC_HI:   new_val = {load_byte, {HALF{1'b0}}};
         AC_LOHI: new_val = {load_byte, lo_hold};
         default: new_val = '0;
      endcase
   end

   assign first_half  = load_we && cfg_seen && (acc_q == AC_LOHI) && !hi_next;
   assign load_done   = load_we && cfg_seen && !((acc_q == AC_LOHI) && !hi_next);
   assign reload_ext  = ext(reload);
   assign sq_high_val = reload[0] ? reload_ext + CNT_ONE : reload_ext;
   assign sq_low_val  = reload[0] ? reload_ext - CNT_ONE : reload_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MD_ONESHOT;
         acc_q    <= AC_NONE;
         cnt      <= '0;
         reload   <= '0;
         lo_hold  <= '0;
         hi_next  <= 1'b0;
         cfg_seen <= 1'b0;
         running  <= 1'b0;
         pending  <= 1'b0;
         gate_q   <= 1'b0;
         out_q    <= 1'b0;
      end else begin
         gate_q <= gate;
         // periodic modes: gate low holds output high, gate rise restarts
         if (cfg_seen && mode_q != MD_ONESHOT) begin
            if (!gate) out_q <= 1'b1;
            if (gate && !gate_q && (running || pending)) pending <= 1'b1;
         end
         if (tick) begin
            if (pending && (mode_q == MD_ONESHOT || gate)) begin
               running <= 1'b1;
               pending <= 1'b0;
               if (mode_q == MD_SQUARE) begin
                  cnt   <= sq_high_val;
                  out_q <= 1'b1;
               end else begin
                  cnt <= reload_ext;
                  if (mode_q == MD_RATE) out_q <= 1'b1;
               end
            end else if (running && gate) begin
               case (mode_q)
                  MD_ONESHOT: begin
                     if (cnt != '0) begin
                        cnt <= cnt - CNT_ONE;
                        if (cnt == CNT_ONE) out_q <= 1'b1;
                     end
                  end
                  MD_RATE: begin
                     if (cnt == CNT_TWO) begin
                        cnt   <= CNT_ONE;
                        out_q <= 1'b0;
                     end else if (cnt == CNT_ONE) begin
                        cnt   <= reload_ext;
                        out_q <= 1'b1;
                     end else begin
                        cnt <= cnt - CNT_ONE;
                     end
                  end
                  MD_SQUARE: begin
                     if (cnt <= CNT_TWO) begin
                        out_q <= !out_q;
                        cnt   <= out_q ? sq_low_val : sq_high_val;
                     end else begin
                        cnt <= cnt - CNT_TWO;
                     end
                  end
                  default: ;
               endcase
            end
         end
         if (first_half) begin
            lo_hold <= load_byte;
            hi_next <= 1'b1;
            if (mode_q == MD_ONESHOT) begin
               out_q   <= 1'b0;
               running <= 1'b0;
               pending <= 1'b0;
            end
         end
         if (load_done) begin
            hi_next <= 1'b0;
            reload  <= new_val;
            if (mode_q == MD_ONESHOT || !running) pending <= 1'b1;
            if (mode_q == MD_ONESHOT) begin
               out_q   <= 1'b0;
               running <= 1'b0;
            end
         end
         if (cfg_we) begin
            mode_q   <= cfg_mode;
            acc_q    <= cfg_acc;
            cfg_seen <= 1'b1;
            running  <= 1'b0;
            pending  <= 1'b0;
            hi_next  <= 1'b0;
            out_q    <= (cfg_mode != MD_ONESHOT);
         end
      end
   end

   assign out_o = out_q;

   // R1: no output before programming
   assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_seen |-> !out_q);
   // R3: the rate-mode low phase lasts one counting pulse
   assert_rate_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_RATE && running && !out_q && tick && gate && !cfg_we) |=> out_q);
   // R4 and R5: square mode always counts on even values
   assert_square_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_SQUARE && running) |-> !cnt[0]);
   // R6: terminal-count output holds high until rewritten
   assert_oneshot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_ONESHOT && out_q && !cfg_we && !load_we) |=> out_q);
   // R9: a low gate forces periodic outputs high
   assert_gate_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_seen && mode_q != MD_ONESHOT && !gate && !cfg_we) |=> out_q);
endmodule

// File: rtl/pc_timer_subsys.sv
`timescale 1ns/1ps
module pc_timer_subsys
   import pst_pkg::*;
#(
   parameter int PRESCALE = 12
) (
   input  logic              osc_clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              port_gate2,
   input  logic              port_spk_en,
   output logic              irq0,
   output logic              refresh_req,
   output logic              speaker
);
   if (PRESCALE < 1) begin : g_bad_prescale
      $error("pc_timer_subsys: PRESCALE must be at least 1");
   end
   if (NUM_CH != 3) begin : g_bad_count
      $error("pc_timer_subsys: fixed routing needs exactly three channels");
   end

   logic              tick;
   ctrl_word_t        cw;
   logic              cw_ok;
   cnt_mode_e         cw_mode;
   logic [NUM_CH-1:0] ch_out;

   pst_prescale #(.DIV(PRESCALE)) u_prescale (
      .clk   (osc_clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   assign cw      = bus_wdata;
   assign cw_mode = mode_map(cw.mode);
   assign cw_ok   = bus_we && (bus_addr == CTRL_ADDR) && (cw.acc != AC_NONE)
                    && !cw.bcd && mode_ok(cw.mode) && (cw.sel != 2'd3);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic ch_gate;
      if (g == 2) begin : g_ext_gate
         assign ch_gate = port_gate2;
      end else begin : g_fixed_gate
         assign ch_gate = 1'b1;
      end

      pst_channel #(.COUNT_W(COUNT_W)) u_ch (
         .clk       (osc_clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .gate      (ch_gate),
         .cfg_we    (cw_ok && (cw.sel == 2'(g))),
         .cfg_mode  (cw_mode),
         .cfg_acc   (cw.acc),
         .load_we   (bus_we && (bus_addr == 2'(g))),
         .load_byte (bus_wdata),
         .out_o     (ch_out[g])
      );
   end

   assign irq0        = ch_out[0];
   assign refresh_req = ch_out[1];
   assign speaker     = ch_out[2] & port_spk_en;
endmodule

// File: tb/pc_timer_subsys_bench.sv
`timescale 1ns/1ps
module pc_timer_subsys_bench;
   localparam int K_WFALL = 0;
   localparam int K_WRISE = 1;
   localparam int K_HIGH  = 2;
   localparam int K_LOW   = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       we = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic       gate2 = 1'b1;
   logic       spk_en = 1'b0;
   logic       irq0, refresh, speaker;
   logic [2:0] obs;

   typedef struct {
      string tag;
      int    kind;
      int    cyc;
   } exp_t;
   exp_t q[$];

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int mon_sel = 0;
   logic [2:0] prev = 3'b000;
   int last_edge [3];
   int dur;

   always #10 clk = ~clk;

   pc_timer_subsys u_pc_timer_subsys (
      .osc_clk     (clk),
      .rst_n       (rst_n),
      .bus_we      (we),
      .bus_addr    (addr),
      .bus_wdata   (wdata),
      .port_gate2  (gate2),
      .port_spk_en (spk_en),
      .irq0        (irq0),
      .refresh_req (refresh),
      .speaker     (speaker)
   );

   assign obs = {speaker, refresh, irq0};

   task automatic check(input string tag, input bit ok, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic push(input string tag, input int kind, input int c);
      exp_t e;
      e.tag = tag;
      e.kind = kind;
      e.cyc = c;
      q.push_back(e);
   endtask

   task automatic handle(input logic lvl, input int d);
      exp_t e;
      e = q[0];
      case (e.kind)
         K_WFALL: if (!lvl) void'(q.pop_front());
         K_WRISE: if (lvl) void'(q.pop_front());
         K_HIGH: begin
            void'(q.pop_front());
            check(e.tag, !lvl && d == e.cyc, d, e.cyc);
         end
         default: begin
            void'(q.pop_front());
            check(e.tag, lvl && d == e.cyc, d, e.cyc);
         end
      endcase
   endtask

   // monitor: measures phase lengths of the selected pin
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         for (int i = 0; i < 3; i++) begin
            if (obs[i] !== prev[i]) begin
               dur = cyc - last_edge[i];
               last_edge[i] = cyc;
               if (i == mon_sel && q.size() > 0) handle(obs[i], dur);
            end
         end
         prev = obs;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk);
      #1 we = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1 we = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(posedge clk);
   endtask

   task automatic hold_level(input string tag, input int idx, input logic lvl, input int n);
      int bad = 0;
      repeat (n) begin
         @(negedge clk);
         if (obs[idx] !== lvl) bad++;
      end
      check(tag, bad == 0, bad, 0);
   endtask

   task automatic oneshot_rise(input string tag);
      int n = 1;
      @(negedge clk);
      check(tag, irq0 === 1'b0, int'(irq0), 0);
      while (irq0 !== 1'b1 && n < 200) begin
         @(negedge clk);
         n++;
      end
      check(tag, n >= 49 && n <= 60, n, 49);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 3; i++) last_edge[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset", obs === 3'b000, int'(obs), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: count before control byte is ignored
      wr(2'd0, 8'd5);
      hold_level("R1 idle", 0, 1'b0, 100);

      // R6: terminal count on channel 0
      wr(2'd3, 8'h10);
      wr(2'd0, 8'd4);
      oneshot_rise("R6 first");
      hold_level("R6 hold", 0, 1'b1, 200);
      wr(2'd0, 8'd4);
      oneshot_rise("R6 rewrite");

      // R2 and R3: rate generator, N=5
      mon_sel = 0;
      wr(2'd3, 8'h14);
      push("R3", K_WFALL, 0);
      push("R3 low", K_LOW, 12);
      push("R2 high", K_HIGH, 48);
      push("R3 low", K_LOW, 12);
      push("R2 high", K_HIGH, 48);
      wr(2'd0, 8'd5);
      drain();

      // R10: new count waits for the next reload
      push("R10", K_WRISE, 0);
      drain();
      push("R10 old", K_HIGH, 48);
      push("R10 low", K_LOW, 12);
      push("R10 new", K_HIGH, 24);
      push("R10 low", K_LOW, 12);
      push("R10 new", K_HIGH, 24);
      wr(2'd0, 8'd3);
      drain();

      // R11: rejected control bytes leave channel 0 running
      wr(2'd3, 8'hD4);
      wr(2'd3, 8'h12);
      wr(2'd3, 8'h04);
      wr(2'd3, 8'h15);
      push("R11", K_WRISE, 0);
      push("R11 high", K_HIGH, 24);
      push("R11 low", K_LOW, 12);
      push("R11 high", K_HIGH, 24);
      drain();

      // R4: square wave even count on refresh (R8 routing)
      mon_sel = 1;
      wr(2'd3, 8'h56);
      push("R4", K_WFALL, 0);
      push("R4 low", K_LOW, 36);
      push("R4 high", K_HIGH, 36);
      push("R4 low", K_LOW, 36);
      push("R4 high", K_HIGH, 36);
      wr(2'd1, 8'd6);
      drain();

      // R5: square wave odd count
      wr(2'd3, 8'h56);
      push("R5", K_WFALL, 0);
      push("R5 low", K_LOW, 36);
      push("R5 high", K_HIGH, 48);
      push("R5 low", K_LOW, 36);
      push("R5 high", K_HIGH, 48);
      wr(2'd1, 8'd7);
      drain();

      // R7: high byte only, N=256
      mon_sel = 0;
      wr(2'd3, 8'h24);
      push("R7", K_WFALL, 0);
      push("R7 hi low", K_LOW, 12);
      push("R7 hi high", K_HIGH, 3060);
      push("R7 hi low", K_LOW, 12);
      wr(2'd0, 8'h01);
      drain();

      // R7: low then high byte, N=259
      mon_sel = 1;
      wr(2'd3, 8'h74);
      wr(2'd1, 8'h03);
      hold_level("R7 half written", 1, 1'b1, 100);
      push("R7", K_WFALL, 0);
      push("R7 both low", K_LOW, 12);
      push("R7 both high", K_HIGH, 3096);
      push("R7 both low", K_LOW, 12);
      wr(2'd1, 8'h01);
      drain();

      // R8 and R9: speaker path
      mon_sel = 2;
      spk_en = 1'b1;
      gate2 = 1'b1;
      wr(2'd3, 8'h96);
      push("R8", K_WFALL, 0);
      push("R8 low", K_LOW, 24);
      push("R8 high", K_HIGH, 24);
      push("R8 low", K_LOW, 24);
      wr(2'd2, 8'd4);
      drain();

      @(posedge clk);
      #1 spk_en = 1'b0;
      repeat (2) @(posedge clk);
      hold_level("R8 disabled", 2, 1'b0, 150);

      @(posedge clk);
      #1 spk_en = 1'b1; gate2 = 1'b0;
      repeat (2) @(posedge clk);
      hold_level("R9 gate low", 2, 1'b1, 150);

      @(posedge clk);
      #1 gate2 = 1'b1;
      push("R9", K_WFALL, 0);
      push("R9 low", K_LOW, 24);
      push("R9 high", K_HIGH, 24);
      drain();

      repeat (5) @(posedge clk);
      summary();
      $finish;
   end
endmodule